// File: doc/BRIEF.md
# Shift Register Configuration and Stop-Position Readback Controller

This controller runs the serial interface of the small write shift register found in a switched-capacitor sampling chip. On a start request it shifts a channel-cascade pattern into the register. It then clocks the register round once more and compares what comes out on the register's dedicated output pin, to confirm that the load took. After that it waits for a trigger. The trigger freezes the sampling, and the register is left holding the position at which the sampling stopped.

Once the trigger has arrived, the controller selects the register on the chip's shared serial readout pin through the address bus. It shifts the register out MSB first and feeds the load pattern back into the serial input while doing so, so that the register is not emptied by the readout. The captured word is then reported. The index of the single set bit in the lowest cascade group is decoded as the stop channel. An error is flagged when that group holds no set bit, or more than one.

The shift-clock half period is given in system clock cycles and is captured at start.

Top module: `wsr_ctrl`

## Requirements
- R1: After reset, sclk, srin, dwrite, busy, done, verify_err, stop_err and reg_q are all 0, and addr equals ADDR_IDLE (default 4'b0000).
- R2: A start pulse while idle (busy=0) latches pattern and shifts it into the chip over REG_W shift-clock rising edges, MSB first. srin holds each bit from before the rising edge until after it.
- R3: Every shift-clock high phase lasts max(half_per,1) clk cycles. Every low phase inside a run of consecutive bits lasts the same. The rising edge of a bit comes at least one cycle after srin changes for that bit.
- R4: Right after the load, REG_W more shift clocks re-drive the pattern on srin and sample wsr_out_i just before each rising edge. If the captured word differs from the pattern, verify_err=1 and the operation ends (done) without waiting for a trigger and without a readback.
- R5: dwrite is 1 from the first load bit until the trigger is accepted. It is 0 during readback and while idle.
- R6: During readback, addr equals 4'b1101 for all REG_W shift clocks and the shared pin srout_i is sampled. At every other time, addr equals ADDR_IDLE.
- R7: During readback, srin re-drives the latched pattern MSB first, so that the chip register holds the pattern again once readback is over.
- R8: After readback, reg_q holds the shifted-out word. The first bit out is reg_q[REG_W-1]. reg_q is stable while idle.
- R9: stop_ch is the index of the single set bit in reg_q[GRP_W-1:0]. If that field has zero set bits or more than one, stop_err=1 and stop_ch=0.
- R10: trig is ignored outside the wait-for-trigger phase, and start is ignored while busy. A later pattern change does not alter the running operation.
- R11: done is a single-cycle pulse that ends every operation. busy is 1 from the cycle after start until done has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load/verify/wait/readback operation |
| pattern | input | REG_W | Cascade pattern to load |
| half_per | input | DIV_W | Shift-clock half period in clk cycles (0 acts as 1) |
| trig | input | 1 | Trigger; accepted only while waiting |
| wsr_out_i | input | 1 | Dedicated register output pin of the chip |
| srout_i | input | 1 | Shared serial readout pin of the chip |
| sclk | output | 1 | Shift clock to the chip |
| srin | output | 1 | Serial input to the chip |
| dwrite | output | 1 | Write-enable level to the chip |
| addr | output | 4 | Chip address bus |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| verify_err | output | 1 | Load verification mismatch |
| reg_q | output | REG_W | Word read back after the trigger |
| stop_ch | output | CH_W | Decoded stop channel within the cascade group |
| stop_err | output | 1 | Cascade group not one-hot |

## Verification
The hardest situation to reach from the ports is a readback whose register contents differ from what was loaded, because a real chip only changes the register through sampling activity. The bench's behavioural chip model overwrites its register with a chosen stop position just before the trigger is pulsed. This sweeps every one-hot position and the empty and multi-bit cases across several shift-clock dividers. A failed verification is produced by holding the model's dedicated output pin low. Stray triggers and starts are injected during load and during the wait.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_VERIFY,
      ST_WAIT,
      ST_READ,
      ST_DONE
   } wsr_state_t;

   // Address code that routes the shift register onto the shared readout pin
   localparam logic [3:0] ADDR_SHIFTREG = 4'b1101;
endpackage

// File: rtl/wsr_sclk_gen.sv
module wsr_sclk_gen #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_per,
   output logic             sclk,
   output logic             rise,
   output logic             fall
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] last;
   logic             hi;
   logic             term;

   assign last = (half_per == '0) ? '0 : half_per - 1'b1;
   assign term = run && (cnt == last);
   assign rise = term && !hi;
   assign fall = term && hi;
   assign sclk = hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         hi  <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         hi  <= 1'b0;
      end else if (term) begin
         cnt <= '0;
         hi  <= ~hi;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/wsr_shifter.sv
module wsr_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         capture,
   input  logic         cap_bit,
   output logic         tx_bit,
   output logic [W-1:0] rx_word
);
   logic [W-1:0] tx;

   assign tx_bit = tx[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx <= '0;
      end else if (load) begin
         tx <= load_val;
      end else if (shift) begin
         tx <= {tx[W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_word <= '0;
      end else if (capture) begin
         rx_word <= {rx_word[W-2:0], cap_bit};
      end
   end
endmodule

// File: rtl/wsr_decode.sv
module wsr_decode #(
   parameter int G  = 4,
   parameter int IW = 2
) (
   input  logic [G-1:0]  grp,
   output logic [IW-1:0] idx,
   output logic          err
);
   generate
      if (G == 1) begin : g_single
         assign idx = '0;
         assign err = !grp[0];
      end else begin : g_multi
         always_comb begin
            idx = '0;
            for (int i = 0; i < G; i++) begin
               if (grp[i]) idx = IW'(i);
            end
            err = ($countones(grp) != 1);
            if (err) idx = '0;
         end
      end
   endgenerate
endmodule

// File: rtl/wsr_ctrl.sv
module wsr_ctrl
   import wsr_pkg::*;
#(
   parameter int          REG_W     = 8,
   parameter int          GRP_W     = 4,
   parameter int          DIV_W     = 4,
   parameter logic [3:0]  ADDR_IDLE = 4'h0,
   localparam int         CH_W      = (GRP_W > 1) ? $clog2(GRP_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [REG_W-1:0] pattern,
   input  logic [DIV_W-1:0] half_per,
   input  logic             trig,
   input  logic             wsr_out_i,
   input  logic             srout_i,
   output logic             sclk,
   output logic             srin,
   output logic             dwrite,
   output logic [3:0]       addr,
   output logic             busy,
   output logic             done,
   output logic             verify_err,
   output logic [REG_W-1:0] reg_q,
   output logic [CH_W-1:0]  stop_ch,
   output logic             stop_err
);
   localparam int BC_W = $clog2(REG_W);

   generate
      if (REG_W < 2) begin : g_bad_width
         $error("REG_W must be at least 2");
      end
      if (GRP_W < 1 || GRP_W > REG_W || (REG_W % GRP_W) != 0) begin : g_bad_group
         $error("GRP_W must divide REG_W");
      end
      if (ADDR_IDLE == ADDR_SHIFTREG) begin : g_bad_addr
         $error("ADDR_IDLE must differ from the readback address");
      end
   endgenerate

   wsr_state_t       state;
   logic [REG_W-1:0] pat_q;
   logic [DIV_W-1:0] hp_q;
   logic [BC_W-1:0]  bcnt;
   logic             run, rise, fall, phase_end;
   logic             capture, cap_bit, tx_load, match;
   logic [REG_W-1:0] rx_word;
   logic [CH_W-1:0]  dec_idx;
   logic             dec_err;
   logic             accept;

   assign accept    = (state == ST_IDLE) && start;
   assign run       = (state == ST_LOAD) || (state == ST_VERIFY) || (state == ST_READ);
   assign phase_end = fall && (bcnt == BC_W'(REG_W - 1));
   assign match     = (rx_word == pat_q);
   assign capture   = rise && ((state == ST_VERIFY) || (state == ST_READ));
   assign cap_bit   = (state == ST_READ) ? srout_i : wsr_out_i;
   assign tx_load   = accept
                    || (phase_end && (state == ST_LOAD))
                    || (phase_end && (state == ST_VERIFY) && match);

   wsr_sclk_gen #(.DIV_W(DIV_W)) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .half_per (hp_q),
      .sclk     (sclk),
      .rise     (rise),
      .fall     (fall)
   );

   wsr_shifter #(.W(REG_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tx_load),
      .load_val (accept ? pattern : pat_q),
      .shift    (fall),
      .capture  (capture),
      .cap_bit  (cap_bit),
      .tx_bit   (srin),
      .rx_word  (rx_word)
   );

   wsr_decode #(.G(GRP_W), .IW(CH_W)) u_dec (
      .grp (rx_word[GRP_W-1:0]),
      .idx (dec_idx),
      .err (dec_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt <= '0;
      end else if (!run || phase_end) begin
         bcnt <= '0;
      end else if (fall) begin
         bcnt <= bcnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE:   if (start) state <= ST_LOAD;
            ST_LOAD:   if (phase_end) state <= ST_VERIFY;
            ST_VERIFY: if (phase_end) state <= match ? ST_WAIT : ST_DONE;
            ST_WAIT:   if (trig) state <= ST_READ;
            ST_READ:   if (phase_end) state <= ST_DONE;
            ST_DONE:   state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pat_q      <= '0;
         hp_q       <= '0;
         verify_err <= 1'b0;
         reg_q      <= '0;
         stop_ch    <= '0;
         stop_err   <= 1'b0;
      end else if (accept) begin
         pat_q      <= pattern;
         hp_q       <= half_per;
         verify_err <= 1'b0;
         stop_err   <= 1'b0;
      end else if (phase_end && (state == ST_VERIFY) && !match) begin
         verify_err <= 1'b1;
      end else if (phase_end && (state == ST_READ)) begin
         reg_q    <= rx_word;
         stop_ch  <= dec_idx;
         stop_err <= dec_err;
      end
   end

   assign dwrite = (state == ST_LOAD) || (state == ST_VERIFY) || (state == ST_WAIT);
   assign addr   = (state == ST_READ) ? ADDR_SHIFTREG : ADDR_IDLE;
   assign busy   = (state != ST_IDLE);
   assign done   = (state == ST_DONE);
endmodule

// File: rtl/wsr_ctrl_chk.sv
module wsr_ctrl_chk #(
   parameter int         REG_W     = 8,
   parameter int         GRP_W     = 4,
   parameter int         DIV_W     = 4,
   parameter logic [3:0] ADDR_IDLE = 4'h0,
   localparam int        CH_W      = (GRP_W > 1) ? $clog2(GRP_W) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             sclk,
   input logic             dwrite,
   input logic [3:0]       addr,
   input logic             busy,
   input logic             done,
   input logic [REG_W-1:0] reg_q,
   input logic [CH_W-1:0]  stop_ch,
   input logic             stop_err
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!sclk && !dwrite && addr == ADDR_IDLE)) else $error("idle outputs"); // R5

   AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 4'b1101) |-> !dwrite) else $error("readback with dwrite"); // R6

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R11

   AST_ERR_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
      stop_err |-> (stop_ch == '0)) else $error("channel not cleared on error"); // R9

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(reg_q)) else $error("result moved while idle"); // R8
endmodule

bind wsr_ctrl wsr_ctrl_chk #(
   .REG_W     (REG_W),
   .GRP_W     (GRP_W),
   .DIV_W     (DIV_W),
   .ADDR_IDLE (ADDR_IDLE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .sclk     (sclk),
   .dwrite   (dwrite),
   .addr     (addr),
   .busy     (busy),
   .done     (done),
   .reg_q    (reg_q),
   .stop_ch  (stop_ch),
   .stop_err (stop_err)
);

// File: tb/wsr_ctrl_test.sv
`timescale 1ns/100ps
module wsr_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] pattern = '0;
   logic [3:0] half_per = 4'd1;
   logic       trig = 1'b0;
   logic       wsr_out_i, srout_i;
   logic       sclk, srin, dwrite, busy, done, verify_err, stop_err;
   logic [3:0] addr;
   logic [7:0] reg_q;
   logic [1:0] stop_ch;

   int n_checks = 0;
   int n_fail = 0;
   int cyc = 0;

   // chip model
   logic [7:0] chip_q = '0;
   bit         pin_stuck = 1'b0;

   // port monitor state
   logic       prev_sclk = 1'b0;
   int         run_len = 0;
   int         rises = 0;
   int         exp_half = 1;
   int         bad_width = 0;
   int         bad_dw = 0;
   int         bad_addr = 0;
   logic       srin_log [0:31];

   always #2.5 clk = ~clk;

   wsr_ctrl uut (
      .clk(clk), .rst_n(rst_n), .start(start), .pattern(pattern),
      .half_per(half_per), .trig(trig), .wsr_out_i(wsr_out_i),
      .srout_i(srout_i), .sclk(sclk), .srin(srin), .dwrite(dwrite),
      .addr(addr), .busy(busy), .done(done), .verify_err(verify_err),
      .reg_q(reg_q), .stop_ch(stop_ch), .stop_err(stop_err)
   );

   always @(posedge sclk) #1 chip_q = {chip_q[6:0], srin};
   assign wsr_out_i = (dwrite && !pin_stuck) ? chip_q[7] : 1'b0;
   assign srout_i   = (addr == 4'b1101) ? chip_q[7] : 1'b0;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
      if (sclk !== prev_sclk) begin
         if (prev_sclk) begin
            if (run_len != exp_half) bad_width++;
         end else begin
            if (rises != 0 && rises != 16 && run_len != exp_half) bad_width++;
            if (rises < 32) srin_log[rises] = srin;
            if (rises < 16 && !dwrite) bad_dw++;
            if (rises < 16 && addr != 4'b0000) bad_addr++;
            if (rises >= 16 && (addr != 4'b1101 || dwrite)) bad_addr++;
            rises++;
         end
         run_len = 1;
      end else begin
         run_len++;
      end
      prev_sclk = sclk;
   end

   function automatic logic [7:0] logged(input int base);
      logic [7:0] w;
      for (int i = 0; i < 8; i++) w[7-i] = srin_log[base+i];
      return w;
   endfunction

   task automatic do_run(input logic [7:0] pat, input logic [7:0] v, input int hp,
                         input bit stuck, input bit stray);
      int g;
      logic [1:0] e_ch;
      bit e_err;
      @(posedge clk); #1;
      rises = 0; bad_width = 0; bad_dw = 0; bad_addr = 0;
      exp_half = (hp == 0) ? 1 : hp;
      pin_stuck = stuck;
      pattern = pat; half_per = 4'(hp); start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      if (stray) begin
         g = 0;
         while (rises < 3 && g < 5000) begin @(negedge clk); g++; end
         @(posedge clk); #1 trig = 1'b1;
         @(posedge clk); #1 trig = 1'b0;
      end
      g = 0;
      while (rises < 16 && g < 5000) begin @(negedge clk); g++; end
      if (!stuck) begin
         repeat (4*exp_half + 6) @(posedge clk);
         #1;
         if (stray) begin
            start = 1'b1; pattern = ~pat;
            @(posedge clk); #1 start = 1'b0; pattern = pat;
            repeat (3) @(posedge clk);
            #1;
         end
         @(negedge clk);
         check(busy && dwrite && rises == 16, "R10 still waiting for trigger",
               {busy, dwrite, 8'(rises)}, {1'b1, 1'b1, 8'd16});
         @(posedge clk); #1;
         chip_q = v; trig = 1'b1;
         @(posedge clk); #1 trig = 1'b0;
      end
      g = 0;
      do begin @(negedge clk); g++; end while (!done && g < 5000);
      check(done, "R11 done reached", done, 1);
      check(logged(0) == pat, "R2 load bits MSB first", logged(0), pat);
      check(logged(8) == pat, "R4 verify re-drive", logged(8), pat);
      check(verify_err == stuck, "R4 verify_err", verify_err, stuck);
      check(bad_width == 0, "R3 shift clock phase width", bad_width, 0);
      if (stuck) begin
         check(rises == 16, "R4 no readback after mismatch", rises, 16);
      end else begin
         check(bad_dw == 0, "R5 dwrite high before trigger", bad_dw, 0);
         check(bad_addr == 0 && rises == 24, "R6 readback address and count",
               {8'(bad_addr), 8'(rises)}, {8'd0, 8'd24});
         check(logged(16) == pat && chip_q == pat, "R7 pattern restored",
               {logged(16), chip_q}, {pat, pat});
         check(reg_q == v, "R8 readback word", reg_q, v);
         e_err = ($countones(v[3:0]) != 1);
         e_ch = 2'd0;
         if (!e_err) for (int i = 0; i < 4; i++) if (v[i]) e_ch = 2'(i);
         check(stop_err == e_err && stop_ch == e_ch, "R9 stop decode",
               {stop_err, stop_ch}, {e_err, e_ch});
      end
      @(negedge clk);
      check(!done && !busy, "R11 single-cycle done", {done, busy}, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!sclk && !srin && !dwrite && !busy && !done, "R1 reset controls",
            {sclk, srin, dwrite, busy, done}, 0);
      check(addr == 4'b0000, "R1 reset address", addr, 0);
      check(!verify_err && !stop_err && reg_q == 8'h00, "R1 reset results",
            {verify_err, stop_err, reg_q}, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      // trigger while idle must be ignored
      @(posedge clk); #1 trig = 1'b1;
      @(posedge clk); #1 trig = 1'b0;
      @(negedge clk);
      check(!busy && !sclk && addr == 4'b0000, "R10 idle trigger ignored",
            {busy, sclk, addr}, 0);
      for (int hp = 1; hp <= 3; hp++) begin
         for (int k = 0; k < 6; k++) begin
            logic [7:0] v;
            if (k < 4) v = {4'b0001 << k, 4'b0001 << k};
            else if (k == 4) v = 8'b1010_0000;
            else v = 8'b0011_0110;
            do_run(8'b0001_0001, v, hp, 1'b0, k == 1);
         end
      end
      do_run(8'hA5, 8'h3C, 0, 1'b0, 1'b0);
      do_run(8'h11, 8'h00, 2, 1'b1, 1'b0);
      do_run(8'h6B, 8'h84, 1, 1'b0, 1'b1);
      repeat (4) @(posedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule